// File: doc/BRIEF.md
# DRAM Page-Burst Sequencer with Selectable Row Release

This block sequences accesses on an external bus shared by DRAM and other memory spaces. Requests come one at a time with a valid/ready handshake. Each request carries an address, write data, a write flag and a tag saying whether it targets DRAM or another space. The block turns each request into bus cycles. An access to a row that is not open gets three cycles: a precharge cycle with the row strobe high, then a row-address cycle that drops the row strobe, then a column cycle that drops the column strobe and moves one data word. An access to a row that is already open gets a single column cycle. An access to another space gets a single external cycle that carries the full address.

A mode input decides what happens to the open row while DRAM accesses pause. In release mode the row strobe goes high as soon as the next cycle is not a DRAM cycle, whether that cycle is an external access or idle. Page bursts therefore only last across back-to-back DRAM requests. In hold mode the row stays open across external accesses and idle cycles. A later DRAM request to the same row then goes straight to a column cycle. A DRAM request to a different row always precharges and reopens, in either mode.

Top module: `dram_page_seq`

## Requirements
- R1: Reset state: during reset and after it, `ras_n` and `cas_n` are 1, `done` and `data_oe` are 0, `bus_addr` is 0 and `req_ready` is 1.
- R2: A DRAM request accepted while no row is open produces three cycles. Cycle 1 is precharge: `ras_n`=1, `cas_n`=1, `bus_addr`=row. Cycle 2 is row-address: `ras_n`=0, `cas_n`=1, `bus_addr`=row. Cycle 3 is column: `ras_n`=0, `cas_n`=0, `bus_addr`=column, `done`=1. The row is `addr[21:10]` and the column is `addr[9:0]`, each zero-extended on the bus.
- R3: A DRAM request to the row that is currently open produces one column cycle. This cycle follows the previous cycle directly, so same-row requests accepted back to back produce one column cycle each, with no gaps.
- R4: A DRAM request to a row other than the open one produces a precharge cycle with `ras_n`=1, then a row-address cycle, then a column cycle.
- R5: A request tagged for another space produces one cycle with `cas_n`=1, `bus_addr` equal to the full 22-bit address and `done`=1.
- R6: With `hold_ras`=0, `ras_n` is 1 during every external-space cycle and every idle cycle that follows a DRAM access. The next DRAM request repeats the precharge and row-address cycles.
- R7: With `hold_ras`=1, `ras_n` stays at its current level across external-space and idle cycles. A later same-row DRAM request then produces only a column cycle.
- R8: `data_oe` is 1 and `bus_wdata` equals the request data only in the column or external cycle of a write. At all other times `data_oe` is 0 and `bus_wdata` is 0.
- R9: `req_ready` is 1 in idle, column and external cycles, and 0 in precharge and row-address cycles. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_ras | input | 1 | 1 keeps the row open across pauses, 0 releases it |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_is_dram | input | 1 | 1 means the request targets DRAM, 0 means another space |
| req_write | input | 1 | 1 means write, 0 means read |
| req_addr | input | 22 | Request address |
| req_wdata | input | 16 | Request write data |
| bus_addr | output | 22 | Multiplexed bus address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| bus_wdata | output | 16 | Data driven onto the shared data bus |
| data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | Final cycle of the current access |

## Verification
A request is accepted at a rising edge, and its first bus cycle appears in the clock cycle right after that edge. A hit takes one cycle. A reopen takes three cycles, with `done` in the third. An external access takes one cycle. Release of the row takes effect in the first cycle that is not a DRAM cycle. The reference model in the bench queues one expected record per future cycle when it decides to present a request. At every falling edge it pops exactly one record and compares it with the outputs, so each result is checked in the cycle it is due and never earlier or later.

// File: rtl/dps_pkg.sv
package dps_pkg;

    parameter int ADDR_W = 22;
    parameter int DATA_W = 16;
    parameter int COL_W  = 10;
    localparam int ROW_W = ADDR_W - COL_W;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_PRE  = 3'd1,
        PH_ROW  = 3'd2,
        PH_COL  = 3'd3,
        PH_EXT  = 3'd4
    } phase_e;

    typedef struct packed {
        logic              is_dram;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } acc_t;

    function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:COL_W];
    endfunction

    function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
        return a[COL_W-1:0];
    endfunction

    function automatic logic phase_accepts(input phase_e p);
        return (p == PH_IDLE) || (p == PH_COL) || (p == PH_EXT);
    endfunction

endpackage

// File: rtl/dps_row_track.sv
module dps_row_track
    import dps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_ras,
    input  phase_e            phase,
    input  phase_e            nxt_phase,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic              row_open,
    output logic              hit
);

    logic [ROW_W-1:0] open_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else begin
            case (nxt_phase)
                PH_PRE: row_open <= 1'b0;
                PH_ROW: begin
                    row_open <= 1'b1;
                    open_row <= row_of(cur_addr);
                end
                PH_EXT, PH_IDLE: begin
                    if (!hold_ras) row_open <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign hit = row_open && (open_row == row_of(cand_addr));

    // R6
    release_drops_row_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXT && !$past(hold_ras)) |-> !row_open);

    // R4
    precharge_closes_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE) |-> !row_open);

endmodule

// File: rtl/dps_seq_fsm.sv
module dps_seq_fsm
    import dps_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  acc_t   req_in,
    input  logic   hit,
    output logic   ready,
    output phase_e phase,
    output phase_e nxt_phase,
    output acc_t   cur
);

    logic accept;

    assign ready  = phase_accepts(phase);
    assign accept = ready && req_valid;

    always_comb begin
        nxt_phase = phase;
        case (phase)
            PH_PRE: nxt_phase = PH_ROW;
            PH_ROW: nxt_phase = PH_COL;
            default: begin
                if (!accept)            nxt_phase = PH_IDLE;
                else if (!req_in.is_dram) nxt_phase = PH_EXT;
                else if (hit)           nxt_phase = PH_COL;
                else                    nxt_phase = PH_PRE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            phase <= nxt_phase;
            if (accept) cur <= req_in;
        end
    end

    // R2
    row_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PRE) |=> (phase == PH_ROW));

    // R3
    col_direct_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COL && $past(phase) != PH_ROW) |-> $past(hit));

    // R9
    no_accept_in_open_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ROW) |-> $past(phase) == PH_PRE);

endmodule

// File: rtl/dps_bus_drive.sv
module dps_bus_drive
    import dps_pkg::*;
(
    input  phase_e            phase,
    input  acc_t              cur,
    input  logic              row_open,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              data_oe,
    output logic              done
);

    logic xfer;

    always_comb begin
        bus_addr = '0;
        case (phase)
            PH_PRE, PH_ROW: bus_addr = ADDR_W'(row_of(cur.addr));
            PH_COL:         bus_addr = ADDR_W'(col_of(cur.addr));
            PH_EXT:         bus_addr = cur.addr;
            default:        bus_addr = '0;
        endcase
    end

    assign xfer      = (phase == PH_COL) || (phase == PH_EXT);
    assign ras_n     = !row_open;
    assign cas_n     = (phase != PH_COL);
    assign done      = xfer;
    assign data_oe   = xfer && cur.write;
    assign bus_wdata = data_oe ? cur.data : '0;

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
    import dps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_ras,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_dram,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              data_oe,
    output logic              done
);

    acc_t   req_in;
    acc_t   cur;
    phase_e phase;
    phase_e nxt_phase;
    logic   row_open;
    logic   hit;

    assign req_in = '{is_dram: req_is_dram, write: req_write,
                      addr: req_addr, data: req_wdata};

    dps_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .hit       (hit),
        .ready     (req_ready),
        .phase     (phase),
        .nxt_phase (nxt_phase),
        .cur       (cur)
    );

    dps_row_track u_rows (
        .clk       (clk),
        .rst       (rst),
        .hold_ras  (hold_ras),
        .phase     (phase),
        .nxt_phase (nxt_phase),
        .cur_addr  (cur.addr),
        .cand_addr (req_addr),
        .row_open  (row_open),
        .hit       (hit)
    );

    dps_bus_drive u_drive (
        .phase     (phase),
        .cur       (cur),
        .row_open  (row_open),
        .bus_addr  (bus_addr),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .bus_wdata (bus_wdata),
        .data_oe   (data_oe),
        .done      (done)
    );

    // R2
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> !ras_n);

    // R8
    drive_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> done);

    // R9
    ready_when_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

endmodule

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb_top;

    typedef struct {
        logic        ras_n;
        logic        cas_n;
        logic [21:0] addr;
        logic        oe;
        logic [15:0] data;
        logic        done;
        logic        ready;
        string       tag;
    } exp_t;

    typedef struct {
        logic        is_dram;
        logic        write;
        logic [21:0] addr;
        logic [15:0] data;
        int          gap;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_ras = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_is_dram = 1'b0;
    logic        req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [21:0] bus_addr;
    logic        ras_n, cas_n, data_oe, done;
    logic [15:0] bus_wdata;

    int compared = 0;
    int mismatched = 0;

    exp_t  expq[$];
    stim_t stimq[$];
    logic        m_open = 1'b0;
    logic [11:0] m_row = '0;
    logic        m_after_pause = 1'b0;

    always #2.5 clk = ~clk;

    dram_page_seq dut_i (
        .clk(clk), .rst(rst), .hold_ras(hold_ras),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_is_dram(req_is_dram), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_addr(bus_addr), .ras_n(ras_n), .cas_n(cas_n),
        .bus_wdata(bus_wdata), .data_oe(data_oe), .done(done)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic push(input logic r, input logic c, input logic [21:0] a,
                        input logic oe, input logic [15:0] d, input logic dn,
                        input logic rdy, input string tag);
        exp_t e;
        e.ras_n = r; e.cas_n = c; e.addr = a; e.oe = oe;
        e.data = oe ? d : 16'h0; e.done = dn; e.ready = rdy; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic add(input logic dram, input logic wr, input logic [11:0] row,
                       input logic [9:0] col, input logic [15:0] d, input int gap);
        stim_t s;
        s.is_dram = dram; s.write = wr; s.addr = {row, col}; s.data = d; s.gap = gap;
        stimq.push_back(s);
    endtask

    task automatic model_accept(input stim_t s);
        logic [11:0] row;
        string tag;
        row = s.addr[21:10];
        if (!s.is_dram) begin
            push(!(hold_ras && m_open), 1'b1, s.addr, s.write, s.data, 1'b1, 1'b1, "R5");
            if (!hold_ras) m_open = 1'b0;
            m_after_pause = 1'b1;
        end else if (m_open && row == m_row) begin
            tag = m_after_pause ? "R7" : "R3";
            push(1'b0, 1'b0, {12'h0, s.addr[9:0]}, s.write, s.data, 1'b1, 1'b1, tag);
            m_after_pause = 1'b0;
        end else begin
            tag = m_open ? "R4" : (m_after_pause ? "R6" : "R2");
            push(1'b1, 1'b1, {10'h0, row}, 1'b0, 16'h0, 1'b0, 1'b0, tag);
            push(1'b0, 1'b1, {10'h0, row}, 1'b0, 16'h0, 1'b0, 1'b0, tag);
            push(1'b0, 1'b0, {12'h0, s.addr[9:0]}, s.write, s.data, 1'b1, 1'b1, tag);
            m_open = 1'b1;
            m_row = row;
            m_after_pause = 1'b0;
        end
    endtask

    task automatic run_queue(input int tail);
        int idle_left;
        idle_left = tail;
        while (stimq.size() > 0 || expq.size() > 0 || idle_left > 0) begin
            exp_t e;
            @(negedge clk);
            if (expq.size() > 0) begin
                e = expq.pop_front();
            end else begin
                e.ras_n = !m_open; e.cas_n = 1'b1; e.addr = '0; e.oe = 1'b0;
                e.data = '0; e.done = 1'b0; e.ready = 1'b1;
                e.tag = hold_ras ? "R7" : "R6";
                if (stimq.size() == 0) idle_left--;
            end
            check(e.tag, "ras_n", 32'(ras_n), 32'(e.ras_n));
            check(e.tag, "cas_n", 32'(cas_n), 32'(e.cas_n));
            check(e.tag, "bus_addr", 32'(bus_addr), 32'(e.addr));
            check(e.tag, "done", 32'(done), 32'(e.done));
            check("R8", "data_oe", 32'(data_oe), 32'(e.oe));
            check("R8", "bus_wdata", 32'(bus_wdata), 32'(e.data));
            check("R9", "req_ready", 32'(req_ready), 32'(e.ready));
            req_valid = 1'b0;
            if (e.ready) begin
                if (stimq.size() > 0 && stimq[0].gap > 0) begin
                    stimq[0].gap--;
                end else if (stimq.size() > 0) begin
                    stim_t s;
                    s = stimq.pop_front();
                    req_valid = 1'b1; req_is_dram = s.is_dram; req_write = s.write;
                    req_addr = s.addr; req_wdata = s.data;
                    model_accept(s);
                end
                if (!req_valid) begin
                    if (!hold_ras) m_open = 1'b0;
                    m_after_pause = 1'b1;
                    req_addr = 22'h3FFFFF; req_wdata = 16'hDEAD;
                end
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs while reset is held
        check("R1", "ras_n", 32'(ras_n), 32'd1);
        check("R1", "cas_n", 32'(cas_n), 32'd1);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "data_oe", 32'(data_oe), 32'd0);
        check("R1", "bus_addr", 32'(bus_addr), 32'd0);
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        rst = 1'b0;

        // Release mode: burst, external break, row change, idle pause
        hold_ras = 1'b0;
        add(1, 1, 12'h005, 10'h001, 16'h1111, 0);
        add(1, 0, 12'h005, 10'h002, 16'h2222, 0);
        add(1, 1, 12'h005, 10'h3FF, 16'h3333, 0);
        add(0, 1, 12'hABC, 10'h155, 16'h4444, 0);
        add(1, 1, 12'h005, 10'h004, 16'h5555, 0);
        add(1, 1, 12'h007, 10'h010, 16'h6666, 0);
        add(1, 0, 12'h007, 10'h011, 16'h7777, 3);
        add(0, 0, 12'h123, 10'h000, 16'h8888, 0);
        add(0, 1, 12'h124, 10'h001, 16'h9999, 0);
        add(1, 1, 12'h007, 10'h012, 16'hAAAA, 0);
        run_queue(4);

        // Hold mode: row survives external access and idle gaps
        @(negedge clk);
        hold_ras = 1'b1;
        add(1, 1, 12'h003, 10'h020, 16'hB001, 0);
        add(0, 1, 12'hF00, 10'h0F0, 16'hB002, 0);
        add(1, 1, 12'h003, 10'h021, 16'hB003, 0);
        add(1, 0, 12'h003, 10'h022, 16'hB004, 2);
        add(1, 1, 12'h009, 10'h000, 16'hB005, 0);
        add(0, 0, 12'h001, 10'h001, 16'hB006, 0);
        add(1, 1, 12'h009, 10'h3FE, 16'hB007, 0);
        add(1, 1, 12'hFFF, 10'h3FF, 16'hB008, 0);
        run_queue(4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        compared++;
        mismatched++;
        $display("FAIL watchdog run did not complete actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule